// File: doc/BRIEF.md
# SPI Transmit/Receive Buffer with Trigger-Level Status

This block holds the data path buffering of an SPI controller. Words written by software enter a transmit queue, and a transmit shift register takes them one at a time. Words that the shift register has received are placed in a receive queue, which software drains. The wire-level clocking is reduced to one strobe that marks the end of a word transfer. When that strobe arrives, the received word is stored and the shift register becomes free.

The block can run as a plain one-word buffer or as an 8-deep queue with programmable thresholds. Three registered status flags follow the mode. With the queue off, they report empty or not empty. With the queue on, they compare the entry counts against the configured trigger levels. A single configuration word sets the queue enable and the two 4-bit levels. The enable cannot change while a word is being shifted.

Top module: `spi_fifo_status`

## Requirements
- R1: After a synchronous reset both queues and the shift register are empty, the configuration reads zero, both sticky error bits are 0, `tx_buf_empty`=1, `tx_all_empty`=1 and `rx_not_empty`=0.
- R2: A configuration write takes the queue enable from bit 10, the receive trigger level from bits 7:4 and the transmit trigger level from bits 3:0. The other bits are ignored. The stored values are visible on `cfg_fifo_en`, `cfg_rx_lvl` and `cfg_tx_lvl`.
- R3: While the shift register is busy, a configuration write leaves the queue enable unchanged but still updates both trigger levels.
- R4: Each queue holds 8 words with the queue enabled and 1 word with it disabled. A transmit write to a full queue is dropped and sets the sticky `tx_overflow` bit.
- R5: A received word that arrives when the receive queue is full is dropped and sets the sticky `rx_overrun` bit.
- R6: When the shift register is idle and the transmit queue holds data at a clock edge, that edge loads the oldest word into `sh_tx_data` and raises `sh_busy`.
- R7: A `shift_done` strobe while busy pushes `shift_rx_data` into the receive queue and clears `sh_busy`. A strobe while idle has no effect.
- R8: `rx_not_empty` is (receive count != 0) with the queue disabled, and (receive count >= receive level) with it enabled.
- R9: `tx_buf_empty` is (transmit count == 0) with the queue disabled, and (transmit count <= transmit level) with it enabled.
- R10: `tx_all_empty` is 1 only when the transmit queue is empty and the shift register is idle.
- R11: All three flags are registered. Each edge samples the counts, configuration and busy state held before that edge, so a flag follows a count change one edge later.
- R12: Words leave each queue in arrival order. `rx_rd_data` shows the oldest received word whenever the receive queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write word |
| tx_wr | input | 1 | Transmit word write |
| tx_wdata | input | 16 | Transmit word |
| rx_rd | input | 1 | Receive word pop |
| rx_rd_data | output | 16 | Oldest received word |
| shift_done | input | 1 | End-of-word strobe from the serial engine |
| shift_rx_data | input | 16 | Word received by the serial engine |
| sh_busy | output | 1 | Shift register holds a word |
| sh_tx_data | output | 16 | Word in the shift register |
| cfg_fifo_en | output | 1 | Stored queue enable |
| cfg_rx_lvl | output | 4 | Stored receive trigger level |
| cfg_tx_lvl | output | 4 | Stored transmit trigger level |
| tx_buf_empty | output | 1 | Transmit buffer empty / at or below level |
| tx_all_empty | output | 1 | Transmit queue and shift register both empty |
| rx_not_empty | output | 1 | Receive buffer not empty / at or above level |
| tx_overflow | output | 1 | Sticky transmit drop |
| rx_overrun | output | 1 | Sticky receive drop |

## Verification
The assertions check on every cycle the rules that can be stated locally:
- The queue counts never exceed the depth, and each accepted push raises the count by one.
- The enable stays put across a write that arrives while the shift register is busy.
- The error bits stay set once set.
- The shift register clears on a strobe and loads when idle with data.
- `tx_all_empty` implies `tx_buf_empty`.

The other behaviours need the bench's scenarios and its reference model. These are the one-edge lag of the flags, the threshold comparisons under shifting trigger levels and mode changes, the one-word capacity in buffer mode, and word ordering through both queues.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int LVL_W      = 4;
  localparam int EN_BIT     = 10;
  localparam int RXLVL_LSB  = 4;
  localparam int TXLVL_LSB  = 0;

  typedef struct packed {
    logic             en;
    logic [LVL_W-1:0] rx_lvl;
    logic [LVL_W-1:0] tx_lvl;
  } sfs_cfg_t;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign drop    = push && (cnt >= cap);
  assign push_ok = push && !drop;
  assign pop_ok  = pop && (cnt != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4: occupancy never goes past the physical depth
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);
  // R12: an accepted lone push grows the queue by exactly one
  a_r12_push_step: assert property (@(posedge clk) disable iff (rst)
    (push_ok && !pop_ok) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_head,
  input  logic          done,
  output logic          tx_take,
  output logic          rx_push,
  output logic          busy,
  output logic [DW-1:0] data
);
  assign tx_take = !busy && tx_avail;
  assign rx_push = busy && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      data <= '0;
    end else if (rx_push) begin
      busy <= 1'b0;
    end else if (tx_take) begin
      busy <= 1'b1;
      data <= tx_head;
    end
  end

  // R7: a completed word frees the shift register
  a_r7_done_frees: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> !busy);
  // R6: an idle register with queued data is loaded at the next edge
  a_r6_idle_loads: assert property (@(posedge clk) disable iff (rst)
    (!busy && tx_avail) |=> busy);
endmodule

// File: rtl/sfs_flags.sv
module sfs_flags #(
  parameter int CW    = 4,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic             busy,
  output logic             tx_buf_empty,
  output logic             tx_all_empty,
  output logic             rx_not_empty
);
  logic tbe_d, rne_d;

  always_comb begin
    if (en) begin
      tbe_d = int'(tx_cnt) <= int'(tx_lvl);
      rne_d = int'(rx_cnt) >= int'(rx_lvl);
    end else begin
      tbe_d = (tx_cnt == '0);
      rne_d = (rx_cnt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf_empty <= 1'b1;
      tx_all_empty <= 1'b1;
      rx_not_empty <= 1'b0;
    end else begin
      tx_buf_empty <= tbe_d;
      tx_all_empty <= (tx_cnt == '0) && !busy;
      rx_not_empty <= rne_d;
    end
  end

  // R10: a fully drained transmit side is also an empty buffer in both modes
  a_r10_all_implies_buf: assert property (@(posedge clk) disable iff (rst)
    tx_all_empty |-> tx_buf_empty);
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_wdata,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_rd_data,
  input  logic             shift_done,
  input  logic [DW-1:0]    shift_rx_data,
  output logic             sh_busy,
  output logic [DW-1:0]    sh_tx_data,
  output logic             cfg_fifo_en,
  output logic [LVL_W-1:0] cfg_rx_lvl,
  output logic [LVL_W-1:0] cfg_tx_lvl,
  output logic             tx_buf_empty,
  output logic             tx_all_empty,
  output logic             rx_not_empty,
  output logic             tx_overflow,
  output logic             rx_overrun
);
  sfs_cfg_t      cfg_q;
  logic [CW-1:0] cap, tx_cnt, rx_cnt;
  logic [DW-1:0] tx_head;
  logic          tx_take, rx_push, tx_drop, rx_drop;
  logic          unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[31:EN_BIT+1], cfg_wdata[EN_BIT-1:8]};
  assign cap = cfg_q.en ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      tx_overflow <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q.rx_lvl <= cfg_wdata[RXLVL_LSB +: LVL_W];
        cfg_q.tx_lvl <= cfg_wdata[TXLVL_LSB +: LVL_W];
        if (!sh_busy) cfg_q.en <= cfg_wdata[EN_BIT];
      end
      if (tx_drop) tx_overflow <= 1'b1;
      if (rx_drop) rx_overrun  <= 1'b1;
    end
  end

  assign cfg_fifo_en = cfg_q.en;
  assign cfg_rx_lvl  = cfg_q.rx_lvl;
  assign cfg_tx_lvl  = cfg_q.tx_lvl;

  sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .cap(cap),
    .push(tx_wr), .push_data(tx_wdata),
    .pop(tx_take), .head(tx_head), .cnt(tx_cnt), .drop(tx_drop)
  );

  sfs_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst),
    .tx_avail(tx_cnt != '0), .tx_head(tx_head), .done(shift_done),
    .tx_take(tx_take), .rx_push(rx_push), .busy(sh_busy), .data(sh_tx_data)
  );

  sfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .cap(cap),
    .push(rx_push), .push_data(shift_rx_data),
    .pop(rx_rd), .head(rx_rd_data), .cnt(rx_cnt), .drop(rx_drop)
  );

  sfs_flags #(.CW(CW), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst(rst),
    .en(cfg_q.en), .rx_lvl(cfg_q.rx_lvl), .tx_lvl(cfg_q.tx_lvl),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .busy(sh_busy),
    .tx_buf_empty(tx_buf_empty), .tx_all_empty(tx_all_empty),
    .rx_not_empty(rx_not_empty)
  );

  // R3: mode bit frozen across writes during a transfer
  a_r3_en_locked: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sh_busy) |=> $stable(cfg_fifo_en));
  // R4: transmit overflow indication is sticky
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_overflow |=> tx_overflow);
  // R5: receive overrun indication is sticky
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |=> rx_overrun);
endmodule

// File: tb/spi_fifo_status_bench.sv
module spi_fifo_status_bench;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_we, tx_wr, rx_rd, shift_done;
  logic [31:0] cfg_wdata;
  logic [DW-1:0] tx_wdata, shift_rx_data, rx_rd_data, sh_tx_data;
  logic sh_busy, cfg_fifo_en, tx_buf_empty, tx_all_empty, rx_not_empty;
  logic tx_overflow, rx_overrun;
  logic [3:0] cfg_rx_lvl, cfg_tx_lvl;

  spi_fifo_status u_spi_fifo_status (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rd_data(rx_rd_data),
    .shift_done(shift_done), .shift_rx_data(shift_rx_data),
    .sh_busy(sh_busy), .sh_tx_data(sh_tx_data),
    .cfg_fifo_en(cfg_fifo_en), .cfg_rx_lvl(cfg_rx_lvl), .cfg_tx_lvl(cfg_tx_lvl),
    .tx_buf_empty(tx_buf_empty), .tx_all_empty(tx_all_empty),
    .rx_not_empty(rx_not_empty), .tx_overflow(tx_overflow), .rx_overrun(rx_overrun)
  );

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  bit done_flag = 0;

  // reference model state
  logic [DW-1:0] mtx[$], mrx[$];
  logic m_en, m_busy, m_ovf, m_ovr, m_tbe, m_tae, m_rne;
  logic [3:0] m_rl, m_tl;
  logic [DW-1:0] m_sh;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    mtx.delete(); mrx.delete();
    m_en = 0; m_rl = 0; m_tl = 0; m_busy = 0; m_sh = 0;
    m_ovf = 0; m_ovr = 0; m_tbe = 1; m_tae = 1; m_rne = 0;
  endfunction

  function automatic void model_step();
    int cap = m_en ? DEPTH : 1;
    int ntx = mtx.size();
    int nrx = mrx.size();
    logic old_busy = m_busy;
    logic fin = shift_done && old_busy;
    logic load = !old_busy && (ntx > 0);
    // R11: flags from pre-edge state
    m_tbe = m_en ? (ntx <= int'(m_tl)) : (ntx == 0);
    m_rne = m_en ? (nrx >= int'(m_rl)) : (nrx != 0);
    m_tae = (ntx == 0) && !old_busy;
    if (load) begin m_sh = mtx.pop_front(); m_busy = 1; end
    if (tx_wr) begin
      if (ntx < cap) mtx.push_back(tx_wdata); else m_ovf = 1;
    end
    if (rx_rd && nrx > 0) void'(mrx.pop_front());
    if (fin) begin
      m_busy = 0;
      if (nrx < cap) mrx.push_back(shift_rx_data); else m_ovr = 1;
    end
    if (cfg_we) begin
      m_rl = cfg_wdata[7:4];
      m_tl = cfg_wdata[3:0];
      if (!old_busy) m_en = cfg_wdata[10];
    end
  endfunction

  task automatic compare_all();
    chk("R2", "cfg_rx_lvl", 32'(cfg_rx_lvl), 32'(m_rl));
    chk("R2", "cfg_tx_lvl", 32'(cfg_tx_lvl), 32'(m_tl));
    chk("R3", "cfg_fifo_en", 32'(cfg_fifo_en), 32'(m_en));
    chk("R4", "tx_overflow", 32'(tx_overflow), 32'(m_ovf));
    chk("R5", "rx_overrun", 32'(rx_overrun), 32'(m_ovr));
    chk("R6", "sh_busy", 32'(sh_busy), 32'(m_busy));
    if (m_busy) chk("R6", "sh_tx_data", 32'(sh_tx_data), 32'(m_sh));
    chk("R8", "rx_not_empty", 32'(rx_not_empty), 32'(m_rne));
    chk("R9", "tx_buf_empty", 32'(tx_buf_empty), 32'(m_tbe));
    chk("R10", "tx_all_empty", 32'(tx_all_empty), 32'(m_tae));
    if (mrx.size() > 0) chk("R12", "rx_rd_data", 32'(rx_rd_data), 32'(mrx[0]));
  endtask

  task automatic cyc(logic tw, logic [15:0] twd, logic rr, logic sd, logic [15:0] srd,
                     logic cw, logic [31:0] cwd);
    tx_wr = tw; tx_wdata = twd; rx_rd = rr; shift_done = sd; shift_rx_data = srd;
    cfg_we = cw; cfg_wdata = cwd;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc_cnt);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst = 1; cfg_we = 0; tx_wr = 0; rx_rd = 0; shift_done = 0;
    cfg_wdata = 0; tx_wdata = 0; shift_rx_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    // R1: reset state
    chk("R1", "tx_buf_empty", 32'(tx_buf_empty), 1);
    chk("R1", "tx_all_empty", 32'(tx_all_empty), 1);
    chk("R1", "rx_not_empty", 32'(rx_not_empty), 0);
    chk("R1", "cfg", 32'({cfg_fifo_en, cfg_rx_lvl, cfg_tx_lvl}), 0);
    chk("R1", "sticky", 32'({tx_overflow, rx_overrun}), 0);

    // R11: flag lags the count by one edge
    cyc(1, 16'hA5A5, 0, 0, 0, 0, 0);
    chk("R11", "tx_buf_empty one edge after push", 32'(tx_buf_empty), 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R11", "tx_buf_empty two edges after push", 32'(tx_buf_empty), 0);
    chk("R6", "loaded word", 32'(sh_tx_data), 32'h A5A5);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R10", "busy shifter keeps tx_all_empty low", 32'(tx_all_empty), 0);
    cyc(0, 0, 0, 1, 16'h1234, 0, 0);
    chk("R7", "strobe frees shifter", 32'(sh_busy), 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R8", "rx_not_empty buffer mode", 32'(rx_not_empty), 1);
    // R7: strobe while idle must not push (would overrun a 1-word buffer)
    cyc(0, 0, 0, 1, 16'hDEAD, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R7", "idle strobe ignored", 32'(rx_overrun), 0);
    chk("R12", "rx head kept", 32'(rx_rd_data), 32'h1234);
    cyc(0, 0, 1, 0, 0, 0, 0);

    // R3: enable locked while busy, levels still written
    cyc(1, 16'h0F0F, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h0000_0432);
    chk("R3", "en locked", 32'(cfg_fifo_en), 0);
    chk("R3", "rx lvl written", 32'(cfg_rx_lvl), 3);
    chk("R3", "tx lvl written", 32'(cfg_tx_lvl), 2);
    cyc(0, 0, 0, 1, 16'h0101, 0, 0);
    // R2: fields at bits 10, 7:4, 3:0 with noise in the other bits
    cyc(0, 0, 1, 0, 0, 1, 32'hFFFF_FB25);
    chk("R2", "en bit 10", 32'(cfg_fifo_en), 0);
    chk("R2", "levels", 32'({cfg_rx_lvl, cfg_tx_lvl}), 32'h25);
    cyc(0, 0, 0, 0, 0, 1, 32'h0000_0425);
    chk("R2", "en set", 32'(cfg_fifo_en), 1);

    // R4: fill the 8-deep queue while the shifter holds one word
    for (int i = 0; i < 10; i++) cyc(1, 16'(i + 16'h100), 0, 0, 0, 0, 0);
    chk("R4", "overflow after >8+1 writes", 32'(tx_overflow), 1);

    // constrained random in both modes
    for (int ph = 0; ph < 6; ph++) begin
      for (int n = 0; n < 2500; n++) begin
        logic [31:0] w = $urandom;
        w[10] = (ph % 2 == 0) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
        cyc($urandom_range(0, 99) < 40, 16'($urandom), $urandom_range(0, 99) < 30 - ph * 3,
            $urandom_range(0, 99) < 25 + ph * 4, 16'($urandom),
            $urandom_range(0, 99) < 3, w);
      end
    end
    finish_run();
  end
endmodule